// File: doc/BRIEF.md
# Forward Parallel Printer Byte Streamer

This block is the host-side engine of a standard parallel printer link, running in the forward direction only. A DMA-style request/acknowledge port loads bytes into an internal FIFO. The engine takes bytes from the FIFO one at a time. For each byte it drives the eight data lines, waits a programmed number of setup clocks, and pulses the active-low strobe for a programmed width. It then keeps the data steady for a programmed hold time. The engine has no acknowledge-pulse input. It starts the next byte only when the peripheral's Busy line, after a two-flop synchronizer, reads low.

The input side works as a valid/ready stream. `wr_req` is the ready signal and is high while the FIFO has a free entry. `wr_ack` is the valid signal, and a byte on `wr_data` is taken on every rising edge where both are high. When `wr_req` is low the source must hold its byte, and an acknowledge in that cycle is dropped. The output side has no back-pressure other than Busy. One byte takes 1 + setup + pulse + hold clocks. With a 50 MHz clock and each of the three phase counts set to 33, one byte takes 100 clocks, about 500 KB/s.

Top module: `lpt_stream_engine`

## Requirements
- R1: In reset and directly after it, `nstrobe` is 1, `pd` is 0, `level` is 0, `empty` is 1, `full` is 0 and `wr_req` is 1.
- R2: `wr_req` is 1 exactly when `level` < DEPTH. A byte is stored on a rising edge where `wr_ack` and `wr_req` are both 1. An acknowledge while `wr_req` is 0 leaves `level` and the FIFO contents unchanged.
- R3: Bytes reach `pd` in the order they were written. `level` counts the stored bytes, `empty` is `level`==0 and `full` is `level`==DEPTH.
- R4: A byte starts only when `enable` is 1, the FIFO is not empty and synchronized Busy is 0. Busy passes through two flops. If Busy falls before rising edge a, the byte starts at edge a+2 and `nstrobe` falls setup clocks later. No acknowledge pulse from the peripheral is needed.
- R5: `pd` takes the new byte max(`setup_cyc`,1) clocks before `nstrobe` falls, and it does not change while `nstrobe` is low.
- R6: `nstrobe` stays low for exactly max(`pulse_cyc`,1) clocks.
- R7: After `nstrobe` rises, `pd` holds for max(`hold_cyc`,1) clocks, followed by at least one idle clock. With Busy low and bytes waiting, successive falling edges of `nstrobe` are 1+S+P+H clocks apart, where S, P and H are the effective counts.
- R8: A count of 0 in any phase field acts as 1.
- R9: While the FIFO is empty, `nstrobe` stays 1 and `pd` keeps the last byte sent.
- R10: Clearing `enable` during a byte lets that byte finish its strobe. No further byte starts until `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new byte transfers to start |
| setup_cyc | input | CNT_W | Clocks of data before strobe falls (0 acts as 1) |
| pulse_cyc | input | CNT_W | Strobe low width in clocks (0 acts as 1) |
| hold_cyc | input | CNT_W | Clocks of data after strobe rises (0 acts as 1) |
| wr_req | output | 1 | Ready: FIFO has a free entry |
| wr_ack | input | 1 | Valid: write `wr_data` this cycle |
| wr_data | input | W | Byte to enqueue |
| pd | output | W | Printer data lines |
| nstrobe | output | 1 | Active-low data strobe |
| busy | input | 1 | Peripheral Busy, asynchronous |
| level | output | $clog2(DEPTH+1) | Number of bytes held in the FIFO |
| empty | output | 1 | FIFO holds no byte |
| full | output | 1 | FIFO holds DEPTH bytes |

## Verification
Two situations are the hardest to reach from the ports. The first is `enable` being cleared while the strobe is actually low. The bench waits at falling clock edges until it sees `nstrobe` low, then drops `enable` in that cycle. It then checks that this one strobe completes and that the FIFO level settles one byte lower. The second is the Busy path through the synchronizer. The bench queues bytes with Busy held high and confirms that nothing moves. It then lowers Busy at a known falling edge and checks the exact clock in which the strobe falls. It raises Busy again during the strobe to show that the next byte waits.

// File: rtl/lpt_stream_pkg.sv
package lpt_stream_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpt_byte_fifo.sv
module lpt_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/lpt_strobe_fsm.sv
module lpt_strobe_fsm
  import lpt_stream_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             avail,
  input  logic             busy_s,
  input  logic [W-1:0]     head,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic [CNT_W-1:0] pulse_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  output logic             pop,
  output logic [W-1:0]     pd,
  output logic             nstrobe,
  output phase_t           phase
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  assign pop  = (phase == PH_IDLE) && enable && avail && !busy_s;
  assign last = (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      pd      <= '0;
      nstrobe <= 1'b1;
    end else begin
      case (phase)
        PH_IDLE: if (pop) begin
          pd    <= head;
          cnt   <= eff(setup_cyc);
          phase <= PH_SETUP;
        end
        PH_SETUP: if (last) begin
          nstrobe <= 1'b0;
          cnt     <= eff(pulse_cyc);
          phase   <= PH_PULSE;
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (last) begin
          nstrobe <= 1'b1;
          cnt     <= eff(hold_cyc);
          phase   <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last) phase <= PH_IDLE;
                 else      cnt   <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpt_stream_engine.sv
module lpt_stream_engine
  import lpt_stream_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic [CNT_W-1:0] pulse_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  output logic             wr_req,
  input  logic             wr_ack,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     pd,
  output logic             nstrobe,
  input  logic             busy,
  output logic [LW-1:0]    level,
  output logic             empty,
  output logic             full
);
  logic         busy_s;
  logic         pop;
  logic [W-1:0] head;
  phase_t       phase;

  lpt_sync #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .d(busy), .q(busy_s)
  );

  lpt_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_ack), .wdata(wr_data), .pop(pop),
    .rdata(head), .level(level), .empty(empty), .full(full)
  );

  lpt_strobe_fsm #(.W(W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .avail(!empty),
    .busy_s(busy_s), .head(head), .setup_cyc(setup_cyc),
    .pulse_cyc(pulse_cyc), .hold_cyc(hold_cyc), .pop(pop), .pd(pd),
    .nstrobe(nstrobe), .phase(phase)
  );

  assign wr_req = !full;
endmodule

// File: rtl/lpt_stream_engine_chk.sv
module lpt_stream_engine_chk
  import lpt_stream_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          busy_s,
  input logic          wr_ack,
  input logic          wr_req,
  input logic          pop,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic [W-1:0]  pd,
  input logic          nstrobe,
  input phase_t        phase
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R3
  level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_req && !pop) |=> (level == $past(level) + 1'b1));

  // R3
  level_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_ack) |=> (level == $past(level) - 1'b1));

  // R5
  data_steady_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nstrobe |-> $stable(pd));

  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && busy_s) |=> (phase == PH_IDLE));

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !enable) |=> (phase == PH_IDLE && nstrobe));

  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && empty) |=> ($stable(pd) && nstrobe));
endmodule

bind lpt_stream_engine lpt_stream_engine_chk #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .busy_s(busy_s),
  .wr_ack(wr_ack), .wr_req(wr_req), .pop(pop), .level(level),
  .empty(empty), .pd(pd), .nstrobe(nstrobe), .phase(phase)
);

// File: tb/lpt_stream_engine_bench.sv
module lpt_stream_engine_bench;
  localparam int PERIOD = 10;
  localparam int W = 8, DEPTH = 8, CNT_W = 8;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int NV = 5;
  // {setup, pulse, hold, bytes}
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'd1, 8'd1, 8'd4},
    {8'd3, 8'd2, 8'd2, 8'd5},
    {8'd0, 8'd0, 8'd0, 8'd3},
    {8'd5, 8'd8, 8'd3, 8'd6},
    {8'd2, 8'd4, 8'd6, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wr_ack = 1'b0, busy = 1'b0;
  logic [CNT_W-1:0] setup_cyc = 1, pulse_cyc = 1, hold_cyc = 1;
  logic [W-1:0] wr_data = '0, pd;
  logic wr_req, nstrobe, empty, full;
  logic [LW-1:0] level;

  always #(PERIOD/2) clk = ~clk;

  lpt_stream_engine #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_lpt_stream_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .setup_cyc(setup_cyc),
    .pulse_cyc(pulse_cyc), .hold_cyc(hold_cyc), .wr_req(wr_req),
    .wr_ack(wr_ack), .wr_data(wr_data), .pd(pd), .nstrobe(nstrobe),
    .busy(busy), .level(level), .empty(empty), .full(full)
  );

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  logic [W-1:0] exp_q [256];
  int wp = 0;
  int exp_s = 1, exp_p = 1, exp_h = 1;
  bit per_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: timing and data order at the printer side
  int cyc = 0, rp = 0, pdc = 0, lw = 0, falls = 0, last_fall = 0;
  bit have_last = 1'b0;
  logic [W-1:0] pd_prev = '0;
  logic ns_prev = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pd != pd_prev) pdc = 1;
      else if (nstrobe) pdc++;
      if (!nstrobe) lw++;
      if (ns_prev && !nstrobe) begin
        falls++;
        mon_checks++;  // R5 setup
        if (pdc != exp_s) begin
          mon_fails++; $display("FAIL R5 setup actual=%0d expected=%0d", pdc, exp_s);
        end
        mon_checks++;  // R3 order
        if (pd != exp_q[rp]) begin
          mon_fails++; $display("FAIL R3 data actual=%0d expected=%0d", pd, exp_q[rp]);
        end
        rp++;
        if (per_on && have_last) begin
          mon_checks++;  // R7 period
          if (cyc - last_fall != 1 + exp_s + exp_p + exp_h) begin
            mon_fails++;
            $display("FAIL R7 period actual=%0d expected=%0d", cyc - last_fall, 1 + exp_s + exp_p + exp_h);
          end
        end
        last_fall = cyc;
        have_last = per_on;
        lw = 1;
      end
      if (!ns_prev && nstrobe) begin
        mon_checks++;  // R6 width
        if (lw != exp_p) begin
          mon_fails++; $display("FAIL R6 width actual=%0d expected=%0d", lw, exp_p);
        end
      end
      if (!per_on) have_last = 1'b0;
    end
    pd_prev = pd;
    ns_prev = nstrobe;
  end

  task automatic push(input logic [W-1:0] b);
    @(negedge clk);
    if (wr_req) begin exp_q[wp] = b; wp++; end
    wr_ack = 1'b1; wr_data = b;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic wait_falls(input int n);
    while (falls < n) @(negedge clk);
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  initial begin : watchdog
    #(PERIOD * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
             checks + mon_checks + 1);
    $finish;
  end

  initial begin : main
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nstrobe == 1'b1, "R1 nstrobe", nstrobe, 1);
    chk(pd == '0, "R1 pd", pd, 0);
    chk(level == '0 && empty && !full, "R1 level", level, 0);
    chk(wr_req == 1'b1, "R2 wr_req reset", wr_req, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(nstrobe == 1'b1 && pd == '0, "R1 after reset", nstrobe, 1);

    // Table: back-to-back streams under several timings (R3 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      int n;
      per_on = 1'b0;
      enable = 1'b0;
      setup_cyc = VEC[v][31:24];
      pulse_cyc = VEC[v][23:16];
      hold_cyc  = VEC[v][15:8];
      n = int'(VEC[v][7:0]);
      exp_s = eff(int'(setup_cyc));
      exp_p = eff(int'(pulse_cyc));
      exp_h = eff(int'(hold_cyc));
      @(negedge clk);
      for (int i = 0; i < n; i++) push(W'(8'h10 * (v + 1) + i + 1));
      chk(int'(level) == n, "R3 level after fill", int'(level), n);
      per_on = 1'b1;
      f0 = falls;
      enable = 1'b1;
      wait_falls(f0 + n);
      repeat (exp_p + exp_h + 3) @(negedge clk);
      chk(empty == 1'b1, "R3 empty after drain", empty, 1);
      chk(pd == exp_q[wp-1], "R9 pd holds last", pd, exp_q[wp-1]);
      enable = 1'b0;
    end
    per_on = 1'b0;

    // R2 fill to full, dropped acknowledge
    setup_cyc = 2; pulse_cyc = 2; hold_cyc = 2;
    exp_s = 2; exp_p = 2; exp_h = 2;
    for (int i = 0; i < DEPTH; i++) push(W'(8'hA0 + i));
    chk(full && !wr_req, "R2 full and no request", wr_req, 0);
    chk(int'(level) == DEPTH, "R3 level at depth", int'(level), DEPTH);
    push(8'hEE);
    chk(int'(level) == DEPTH, "R2 ack while full ignored", int'(level), DEPTH);
    f0 = falls;
    enable = 1'b1;
    wait_falls(f0 + DEPTH);
    repeat (20) @(negedge clk);
    chk(falls == f0 + DEPTH && empty, "R2 no extra byte", falls - f0, DEPTH);
    enable = 1'b0;

    // R4 Busy gating through the synchronizer
    setup_cyc = 3; exp_s = 3;
    busy = 1'b1;
    push(8'h5A); push(8'h5B);
    enable = 1'b1;
    f0 = falls;
    repeat (30) @(negedge clk);
    chk(falls == f0 && nstrobe, "R4 busy high blocks start", falls - f0, 0);
    busy = 1'b0;
    repeat (exp_s + 2) @(negedge clk);
    chk(nstrobe == 1'b1, "R4 strobe not yet", nstrobe, 1);
    @(negedge clk);
    chk(nstrobe == 1'b0, "R4 strobe after sync latency", nstrobe, 0);
    busy = 1'b1;
    repeat (30) @(negedge clk);
    chk(falls == f0 + 1 && int'(level) == 1, "R4 next byte waits on busy", falls - f0, 1);
    busy = 1'b0;
    wait_falls(f0 + 2);
    repeat (10) @(negedge clk);
    chk(empty == 1'b1, "R4 drained after busy low", empty, 1);
    enable = 1'b0;

    // R10 enable cleared while strobe is low
    setup_cyc = 2; pulse_cyc = 3; exp_s = 2; exp_p = 3;
    push(8'h61); push(8'h62); push(8'h63);
    f0 = falls;
    enable = 1'b1;
    while (nstrobe) @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk(nstrobe == 1'b1 && falls == f0 + 1, "R10 current byte finished", falls - f0, 1);
    chk(int'(level) == 2, "R10 no further byte", int'(level), 2);
    chk(pd == 8'h61, "R10 pd kept", pd, 8'h61);
    enable = 1'b1;
    wait_falls(f0 + 3);
    repeat (30) @(negedge clk);
    // R9 idle on empty
    chk(empty && nstrobe == 1'b1, "R9 strobe high when empty", nstrobe, 1);
    chk(pd == 8'h63, "R9 pd holds last byte", pd, 8'h63);
    chk(rp == wp, "R3 all bytes sent", rp, wp);

    $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
             checks + mon_checks);
    $finish;
  end
endmodule